// File: doc/BRIEF.md
# Motor Bridge Supervisor

This block decides, cycle by cycle, whether the two power bridges of a stepper driver may conduct, whether the step translator must be held at its home position, and whether step commands are accepted. It combines three control inputs with five digital fault flags. The control inputs are an active-high output-disable request, an active-low sleep request and an active-low home/reset request. The fault flags are short-to-ground, overtemperature, logic-supply undervoltage, charge-pump undervoltage and regulator fault. The analog comparators that raise these flags sit elsewhere.

The faults fall into three classes. A short-to-ground is latched and stays latched until the part passes through sleep or loses logic power. Overtemperature, charge-pump undervoltage and regulator faults block the bridges only while they are present. Logic-supply undervoltage behaves like a power-on event: the translator is sent home and the wake-up timer starts again. Once sleep is released, a cycle counter measures the required settling time, and step edges that arrive before it expires are dropped. The output-disable request gates only the bridges, so stepping and sequencing carry on while it is active.

Top module: `drv_guard`

## Requirements
- R1: `bridge_en_o` is high in the cycle after a clock edge only if, at that edge, `sleep_ni`=1, `home_ni`=1, `drv_off_i`=0, all five fault flags are 0 and no short is latched. Otherwise it is low.
- R2: `drv_off_i`=1 lowers `bridge_en_o` one edge later but has no effect on `step_ready_o`, `home_req_o` or on step pulses being issued.
- R3: `home_ni`=0 raises `home_req_o`, lowers `bridge_en_o` and `step_ready_o` one edge later, and step edges seen during that time produce no pulse.
- R4: A clock edge that sees `flt_short_i`=1 while `sleep_ni`=1 sets the short latch (`short_flag_o`=1, `bridge_en_o`=0, `home_req_o`=1). The latch stays set after the flag drops and clears only at an edge that sees `sleep_ni`=0, or at reset.
- R5: `flt_hot_i`, `flt_uv_pump_i` and `flt_reg_i` lower `bridge_en_o` only while they are present, and the bridges come back one edge after they clear. `flt_hot_i` also raises `home_req_o` and lowers `step_ready_o`. The pump and regulator flags do neither.
- R6: `flt_uv_logic_i`=1 lowers `bridge_en_o`, raises `home_req_o`, lowers `step_ready_o` and restarts the wake-up count.
- R7: `sleep_ni`=0 lowers `bridge_en_o` and `step_ready_o`, raises `home_req_o` and clears the wake-up count.
- R8: After reset, sleep release or the end of logic undervoltage, the first edge that sees `sleep_ni`=1 and `flt_uv_logic_i`=0 is count 1. `step_ready_o` is still low after edge WAKE_CYCLES and goes high after edge WAKE_CYCLES+1, provided no other condition blocks it.
- R9: A rising edge on `step_i` yields exactly one one-cycle `step_pulse_o`. The pulse appears after the third clock edge that sees `step_i` high (two synchronizer stages plus the pulse register). It is issued only if `step_ready_o` was high in the cycle the edge was detected, and is otherwise discarded.
- R10: During reset, `bridge_en_o`, `step_ready_o`, `step_pulse_o` and `short_flag_o` are 0 and `home_req_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (logic power present) |
| drv_off_i | input | 1 | High: turn bridges off, keep sequencing |
| sleep_ni | input | 1 | Low: sleep request |
| home_ni | input | 1 | Low: hold translator at home, bridges off |
| step_i | input | 1 | Raw step input, rising edge advances |
| flt_short_i | input | 1 | Short-to-ground detected |
| flt_hot_i | input | 1 | Overtemperature (hysteresis applied upstream) |
| flt_uv_logic_i | input | 1 | Logic-supply undervoltage |
| flt_uv_pump_i | input | 1 | Charge-pump undervoltage |
| flt_reg_i | input | 1 | Gate regulator fault |
| bridge_en_o | output | 1 | Enable to both bridges |
| home_req_o | output | 1 | Translator home/reset request |
| step_ready_o | output | 1 | Step commands accepted |
| step_pulse_o | output | 1 | One-cycle pulse per accepted step edge |
| short_flag_o | output | 1 | Short-to-ground latch state |

## Verification
The bench goes after four corner cases. The first is the exact edge on which the wake-up timer releases stepping: an off-by-one counter would make step-ready appear one cycle early or late. The second is a short flag that lasts a single cycle: a design that does not latch it would re-enable the bridges as soon as the flag drops. The third is step edges during wake-up or home hold: a design without gating would emit pulses that move the motor away from home. The fourth is output-disable: a design that ties it into the step path would stall stepping while the bridges are off. A fixed-seed random phase also mixes fault flags, sleep and control inputs against a bench model, so that self-clearing and latched faults overlap.

// File: rtl/drv_guard_pkg.sv
package drv_guard_pkg;

    typedef struct packed {
        logic bridge_en;
        logic home_req;
        logic step_ready;
        logic short_lat;
    } guard_state_t;

    localparam guard_state_t GUARD_RESET = '{
        bridge_en:  1'b0,
        home_req:   1'b1,
        step_ready: 1'b0,
        short_lat:  1'b0
    };

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic pulse;
    } step_state_t;

endpackage

// File: rtl/drv_guard_wake.sv
module drv_guard_wake #(
    parameter int WAKE_CYCLES = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hold_i,
    output logic ready_o
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (hold_i)             cnt_d = '0;
        else if (cnt_q == LIMIT) cnt_d = cnt_q;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign ready_o = (cnt_q == LIMIT);

    // R8
    wake_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> $past(!hold_i));

    // R7
    wake_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> (cnt_q == '0));

endmodule

// File: rtl/drv_guard_step.sv
module drv_guard_step
    import drv_guard_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_i,
    input  logic allow_i,
    output logic pulse_o
);
    step_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.s1    = step_i;
        st_d.s2    = st_q.s1;
        st_d.s3    = st_q.s2;
        st_d.pulse = st_q.s2 & ~st_q.s3 & allow_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // R9
    pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/drv_guard.sv
module drv_guard
    import drv_guard_pkg::*;
#(
    parameter int WAKE_CYCLES = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic drv_off_i,
    input  logic sleep_ni,
    input  logic home_ni,
    input  logic step_i,
    input  logic flt_short_i,
    input  logic flt_hot_i,
    input  logic flt_uv_logic_i,
    input  logic flt_uv_pump_i,
    input  logic flt_reg_i,
    output logic bridge_en_o,
    output logic home_req_o,
    output logic step_ready_o,
    output logic step_pulse_o,
    output logic short_flag_o
);
    guard_state_t st_d, st_q;
    logic wake_hold, wake_ready;

    assign wake_hold = ~sleep_ni | flt_uv_logic_i;

    drv_guard_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (wake_hold),
        .ready_o(wake_ready)
    );

    drv_guard_step u_step (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (step_i),
        .allow_i(st_q.step_ready),
        .pulse_o(step_pulse_o)
    );

    always_comb begin
        st_d = st_q;
        st_d.short_lat  = sleep_ni & (st_q.short_lat | flt_short_i);
        st_d.bridge_en  = sleep_ni & home_ni & ~drv_off_i & ~flt_uv_logic_i
                        & ~flt_hot_i & ~flt_uv_pump_i & ~flt_reg_i & ~st_d.short_lat;
        st_d.home_req   = ~sleep_ni | ~home_ni | flt_uv_logic_i | flt_hot_i
                        | st_d.short_lat;
        st_d.step_ready = wake_ready & sleep_ni & home_ni & ~flt_uv_logic_i
                        & ~flt_hot_i & ~st_d.short_lat;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= GUARD_RESET;
        else         st_q <= st_d;
    end

    assign bridge_en_o  = st_q.bridge_en;
    assign home_req_o   = st_q.home_req;
    assign step_ready_o = st_q.step_ready;
    assign short_flag_o = st_q.short_lat;

    // R1
    en_inputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bridge_en_o |-> $past(sleep_ni && home_ni && !drv_off_i));

    // R4
    short_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (short_flag_o && sleep_ni) |=> short_flag_o);

    // R7
    sleep_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sleep_ni |=> (!bridge_en_o && !step_ready_o && home_req_o));

    // R6
    uv_home_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flt_uv_logic_i |=> (home_req_o && !bridge_en_o && !step_ready_o));

    // R3
    home_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !home_ni |=> (home_req_o && !bridge_en_o));

endmodule

// File: tb/drv_guard_test.sv
module drv_guard_test;
    localparam int W = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_off = 1'b0, sleep_n = 1'b1, home_n = 1'b1, step = 1'b0;
    logic f_short = 1'b0, f_hot = 1'b0, f_uvl = 1'b0, f_uvp = 1'b0, f_reg = 1'b0;
    logic en, home, rdy, pulse, shrt;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // bench model state
    logic m_short, m_en, m_home, m_rdy, m_pulse, m_s1, m_s2, m_s3;
    int   m_cnt;

    always #2.5 clk = ~clk;

    drv_guard #(.WAKE_CYCLES(W)) uut (
        .clk_i(clk), .rst_ni(rst_n), .drv_off_i(drv_off), .sleep_ni(sleep_n),
        .home_ni(home_n), .step_i(step), .flt_short_i(f_short), .flt_hot_i(f_hot),
        .flt_uv_logic_i(f_uvl), .flt_uv_pump_i(f_uvp), .flt_reg_i(f_reg),
        .bridge_en_o(en), .home_req_o(home), .step_ready_o(rdy),
        .step_pulse_o(pulse), .short_flag_o(shrt)
    );

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_short = 0; m_en = 0; m_home = 1; m_rdy = 0; m_pulse = 0;
        m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0;
    endtask

    function automatic logic nxt_short();
        return sleep_n & (m_short | f_short);
    endfunction

    task automatic model_step();
        logic sh, wok;
        sh  = nxt_short();
        wok = (m_cnt == W);
        m_pulse = m_s2 & ~m_s3 & m_rdy;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = step;
        m_en   = sleep_n & home_n & ~drv_off & ~f_uvl & ~f_hot & ~f_uvp & ~f_reg & ~sh;
        m_home = ~sleep_n | ~home_n | f_uvl | f_hot | sh;
        m_rdy  = wok & sleep_n & home_n & ~f_uvl & ~f_hot & ~sh;
        m_short = sh;
        if (~sleep_n | f_uvl) m_cnt = 0;
        else if (m_cnt != W)  m_cnt = m_cnt + 1;
    endtask

    // one clock with model update and comparison of every output
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R1 bridge_en", en, m_en);
        chk("R3 home_req", home, m_home);
        chk("R8 step_ready", rdy, m_rdy);
        chk("R9 step_pulse", pulse, m_pulse);
        chk("R4 short_flag", shrt, m_short);
    endtask

    task automatic cycn(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int pcount;
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 en", en, 1'b0);
        chk("R10 home", home, 1'b1);
        chk("R10 ready", rdy, 1'b0);
        chk("R10 pulse", pulse, 1'b0);
        chk("R10 short", shrt, 1'b0);
        rst_n = 1'b1;

        // R8 wake delay from power-on, with a step edge discarded meanwhile (R9)
        step = 1'b1; cycn(4); step = 1'b0;
        cycn(W - 4);
        chk("R8 not ready at W", rdy, 1'b0);
        chk("R9 no pulse during wake", pulse, 1'b0);
        cyc();
        chk("R8 ready at W+1", rdy, 1'b1);
        chk("R1 bridges on", en, 1'b1);

        // R9 accepted step: pulse after third edge
        step = 1'b1; cycn(2);
        chk("R9 no pulse yet", pulse, 1'b0);
        cyc();
        chk("R9 pulse", pulse, 1'b1);
        cyc();
        chk("R9 single cycle", pulse, 1'b0);
        step = 1'b0; cycn(2);

        // R2 drive-off keeps stepping
        drv_off = 1'b1; cyc();
        chk("R2 en off", en, 1'b0);
        chk("R2 ready kept", rdy, 1'b1);
        chk("R2 home unaffected", home, 1'b0);
        step = 1'b1; cycn(3);
        chk("R2 pulse while off", pulse, 1'b1);
        step = 1'b0; drv_off = 1'b0; cycn(2);

        // R4 one-cycle short latches
        f_short = 1'b1; cyc(); f_short = 1'b0; cycn(3);
        chk("R4 latched", shrt, 1'b1);
        chk("R4 en off", en, 1'b0);
        chk("R4 home", home, 1'b1);
        // R7 sleep clears latch and readiness
        sleep_n = 1'b0; cyc();
        chk("R4 cleared by sleep", shrt, 1'b0);
        chk("R7 en off", en, 1'b0);
        chk("R7 not ready", rdy, 1'b0);
        chk("R7 home", home, 1'b1);
        cycn(3); sleep_n = 1'b1;
        cycn(W);
        chk("R8 wake after sleep", rdy, 1'b0);
        cyc();
        chk("R8 ready after sleep", rdy, 1'b1);

        // R5 self-clearing faults
        f_hot = 1'b1; cyc();
        chk("R5 hot en", en, 1'b0);
        chk("R5 hot home", home, 1'b1);
        f_hot = 1'b0; cyc();
        chk("R5 hot recovers", en, 1'b1);
        f_uvp = 1'b1; cyc();
        chk("R5 pump en", en, 1'b0);
        chk("R5 pump no home", home, 1'b0);
        chk("R5 pump ready", rdy, 1'b1);
        f_uvp = 1'b0; f_reg = 1'b1; cyc();
        chk("R5 reg en", en, 1'b0);
        f_reg = 1'b0; cyc();
        chk("R5 reg recovers", en, 1'b1);

        // R6 logic undervoltage restarts wake
        f_uvl = 1'b1; cyc();
        chk("R6 en", en, 1'b0);
        chk("R6 home", home, 1'b1);
        chk("R6 ready", rdy, 1'b0);
        f_uvl = 1'b0; cycn(W);
        chk("R6 wake restarted", rdy, 1'b0);
        cyc();

        // R3 home hold discards steps
        home_n = 1'b0; cyc();
        chk("R3 home", home, 1'b1);
        chk("R3 en", en, 1'b0);
        chk("R3 ready", rdy, 1'b0);
        step = 1'b1; pcount = 0;
        for (int i = 0; i < 4; i++) begin cyc(); if (pulse) pcount++; end
        chk("R3 steps dropped", pcount != 0, 1'b0);
        step = 1'b0; home_n = 1'b1; cycn(3);

        // random phase against the model
        for (int i = 0; i < 6000; i++) begin
            drv_off = ($urandom_range(0, 9) == 0);
            sleep_n = ($urandom_range(0, 199) != 0);
            home_n  = ($urandom_range(0, 49) != 0);
            step    = $urandom_range(0, 1);
            f_short = ($urandom_range(0, 299) == 0);
            f_hot   = ($urandom_range(0, 59) == 0);
            f_uvl   = ($urandom_range(0, 399) == 0);
            f_uvp   = ($urandom_range(0, 59) == 0);
            f_reg   = ($urandom_range(0, 59) == 0);
            cyc();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule